// File: doc/BRIEF.md
# Two-Vector Testable Master-Slave D Flip-Flop

This block is a bank of edge-triggered D flip-flops. Each bit is built from two conservative latches, and every gate in those latches is a three-line, ones-preserving element: a controlled swap. The first latch, called the leader, is open while the clock is high. The second latch, called the follower, is open while the clock is low. Because the follower opens on the opposite level, both latches take the same clock line and no inverter is needed. The stored value therefore appears on `q_o` after each falling clock edge.

Each latch has a second swap element. That element copies the latch value so that no wire fans out, and it produces the feedback line. Two control pins per latch choose what the feedback line carries:

- In normal operation it carries the latch value.
- In the two test codes it is forced to a constant, which breaks the storage loop.

With the loop broken, the whole bank becomes a combinational conservative network. Two vectors then test it fully:

- All lines at 0 exposes any stuck-at-1 fault.
- All lines at 1 exposes any stuck-at-0 fault.

A built-in ones-count monitor flags any line that disagrees while one of these two vectors is applied.

Top module: `tcff_ms`

## Requirements
- R1: With the normal code (`ldr_c1_i`=0, `ldr_c2_i`=1, `flw_c1_i`=0, `flw_c2_i`=1), `q_o` takes the value `d_i` had at the most recent falling clock edge. It then holds that value until the next falling edge, including through the rising edge.
- R2: With the normal code, `ldr_t1_o` follows `d_i` while the clock is high. While the clock is low it holds the value `d_i` had at the falling edge, even if `d_i` changes.
- R3: With the normal code, `flw_t1_o` always equals `q_o`.
- R4: With all four control pins at 0 (the stuck-at-1 test code), `ldr_t1_o` and `flw_t1_o` are 0 at once, whatever `d_i` and the clock are doing.
- R5: With all four control pins at 1 (the stuck-at-0 test code), `ldr_t1_o` and `flw_t1_o` are 1 at once, whatever `d_i` and the clock are doing.
- R6: All-0s vector: with the stuck-at-1 code, the clock low and `d_i` all 0, every output line is 0. This covers `q_o`, both feedback copies and all `GARB_PER_BIT`=5 garbage lines per bit.
- R7: All-1s vector: with the stuck-at-0 code, the clock high and `d_i` all 1, every one of those output lines is 1.
- R8: `tv_apply_o` is 1 exactly when the R6 vector or the R7 vector is applied. `tv_err_o` is 1 only while such a vector is applied and the ones-count of the output lines differs from the value that vector requires (0 for the all-0s vector, all lines for the all-1s vector).
- R9: Only the normal code and the two test codes are defined. The environment drives no other combination of control pins.
- R10: After a test code, the first falling edge under the normal code restores R1. No trace of the test period remains visible on `q_o`.
- R11: The `WIDTH` bits operate independently. Each bit of `q_o` depends only on the same bit of `d_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock. Opens the leader latch when high and the follower latch when low |
| d_i | input | WIDTH | Data in |
| ldr_c1_i | input | 1 | Leader latch control 1 |
| ldr_c2_i | input | 1 | Leader latch control 2 |
| flw_c1_i | input | 1 | Follower latch control 1 |
| flw_c2_i | input | 1 | Follower latch control 2 |
| q_o | output | WIDTH | Flip-flop output |
| ldr_t1_o | output | WIDTH | Leader feedback copy |
| flw_t1_o | output | WIDTH | Follower feedback copy |
| garb_o | output | 5*WIDTH | Garbage lines, five per bit |
| tv_apply_o | output | 1 | A two-vector test pattern is applied |
| tv_err_o | output | 1 | Ones-count mismatch under an applied test pattern |

## Verification
Data is driven with all-zero, all-one and alternating bit patterns, then random words. `d_i` changes both in the high phase and in the low phase. Changes in the low phase show whether the leader really holds, as opposed to a level-transparent path. Checking `q_o` right after the rising edge shows whether the block acts on the falling edge rather than the rising one. Each test code is applied twice: once with its matching uniform vector and once with the clock phase or data mismatched. The first case proves that every line is driven to the constant. The second proves that `tv_apply_o` qualifies only the true vector and that the feedback copies stay forced regardless. A final return to the normal code proves that the first falling edge recovers clean operation.

// File: rtl/tcff_pkg.sv
package tcff_pkg;
    // Garbage lines produced per flip-flop bit:
    // leader gate-1 spare, leader gate-2 spare,
    // follower gate-1 spare, follower gate-2 spare, follower clock copy.
    localparam int GARB_PER_BIT = 5;
    // Observable lines per bit: q, two feedback copies, plus garbage.
    localparam int LINES_PER_BIT = 3 + GARB_PER_BIT;

    typedef enum logic [3:0] {
        CODE_SA1  = 4'b0000,
        CODE_NORM = 4'b0101,
        CODE_SA0  = 4'b1111
    } tcff_code_e;

    typedef struct packed {
        logic ldr_hold;
        logic flw_hold;
    } tcff_state_t;
endpackage

// File: rtl/tcff_swap.sv
// Three-line conservative controlled swap: the ones-count on the outputs
// always equals the ones-count on the inputs.
module tcff_swap (
    input  logic ctl_i,
    input  logic x_i,
    input  logic y_i,
    output logic pass_o,
    output logic sel_y_o,
    output logic sel_x_o
);
    always_comb begin
        pass_o  = ctl_i;
        sel_y_o = ctl_i ? y_i : x_i;
        sel_x_o = ctl_i ? x_i : y_i;
    end
endmodule

// File: rtl/tcff_latch.sv
// Testable conservative latch built from two swap elements.
// POS_EN=1: transparent while en_i is high; POS_EN=0: while en_i is low.
// held_i is the value last captured when the latch closed.
module tcff_latch #(
    parameter bit POS_EN = 1'b1
) (
    input  logic en_i,
    input  logic din_i,
    input  logic c1_i,
    input  logic c2_i,
    input  logic held_i,
    output logic lq_o,
    output logic t1_o,
    output logic gx_o,
    output logic gy_o,
    output logic en_o,
    output logic fb_o
);
    logic fb;
    logic g1_y;
    logic g1_x;
    logic lat;

    // The feedback line as the second element delivers it around the
    // loop: the stored value when c1/c2 = 0/1, a constant for 00 or 11.
    always_comb fb = held_i ? c2_i : c1_i;

    tcff_swap u_g1 (
        .ctl_i  (en_i),
        .x_i    (din_i),
        .y_i    (fb),
        .pass_o (en_o),
        .sel_y_o(g1_y),
        .sel_x_o(g1_x)
    );

    generate
        if (POS_EN) begin : g_pos
            always_comb begin
                lat  = g1_x;
                gx_o = g1_y;
            end
        end else begin : g_neg
            always_comb begin
                lat  = g1_y;
                gx_o = g1_x;
            end
        end
    endgenerate

    tcff_swap u_g2 (
        .ctl_i  (lat),
        .x_i    (c1_i),
        .y_i    (c2_i),
        .pass_o (lq_o),
        .sel_y_o(t1_o),
        .sel_x_o(gy_o)
    );

    always_comb fb_o = fb;
endmodule

// File: rtl/tcff_slice.sv
// One flip-flop bit: positive-enable leader feeding a negative-enable follower.
module tcff_slice
    import tcff_pkg::*;
(
    input  logic                    clk_i,
    input  logic                    d_i,
    input  logic                    ldr_c1_i,
    input  logic                    ldr_c2_i,
    input  logic                    flw_c1_i,
    input  logic                    flw_c2_i,
    output logic                    q_o,
    output logic                    ldr_t1_o,
    output logic                    flw_t1_o,
    output logic [GARB_PER_BIT-1:0] garb_o
);
    tcff_state_t st_d;
    logic        ldr_hold_q;
    logic        flw_hold_q;

    logic ldr_q, ldr_gx, ldr_gy, clk_copy, ldr_fb;
    logic flw_gx, flw_gy, flw_clk, flw_fb;

    tcff_latch #(.POS_EN(1'b1)) u_ldr (
        .en_i  (clk_i),
        .din_i (d_i),
        .c1_i  (ldr_c1_i),
        .c2_i  (ldr_c2_i),
        .held_i(ldr_hold_q),
        .lq_o  (ldr_q),
        .t1_o  (ldr_t1_o),
        .gx_o  (ldr_gx),
        .gy_o  (ldr_gy),
        .en_o  (clk_copy),
        .fb_o  (ldr_fb)
    );

    tcff_latch #(.POS_EN(1'b0)) u_flw (
        .en_i  (clk_copy),
        .din_i (ldr_q),
        .c1_i  (flw_c1_i),
        .c2_i  (flw_c2_i),
        .held_i(flw_hold_q),
        .lq_o  (q_o),
        .t1_o  (flw_t1_o),
        .gx_o  (flw_gx),
        .gy_o  (flw_gy),
        .en_o  (flw_clk),
        .fb_o  (flw_fb)
    );

    // Next held values, taken only from signals that do not move with the
    // closing edge: the leader closes with d_i on its input, the follower
    // closes with the leader's held feedback on its input.
    always_comb begin
        st_d.ldr_hold = d_i;
        st_d.flw_hold = ldr_fb;
    end

    always_ff @(negedge clk_i) ldr_hold_q <= st_d.ldr_hold;
    always_ff @(posedge clk_i) flw_hold_q <= st_d.flw_hold;

    always_comb garb_o = {flw_clk, flw_gy, flw_gx, ldr_gy, ldr_gx};

    logic unused_fb;
    always_comb unused_fb = flw_fb;
endmodule

// File: rtl/tcff_vec_mon.sv
// Ones-count monitor for the two uniform test vectors.
module tcff_vec_mon
    import tcff_pkg::*;
#(
    parameter int WIDTH = 4,
    localparam int NLINES = WIDTH * LINES_PER_BIT
) (
    input  logic              clk_i,
    input  logic [WIDTH-1:0]  d_i,
    input  logic [3:0]        code_i,
    input  logic [NLINES-1:0] lines_i,
    output logic              apply_o,
    output logic              err_o
);
    logic        vec0;
    logic        vec1;
    int unsigned ones;

    always_comb begin
        vec0    = (code_i == CODE_SA1) && (d_i == '0) && !clk_i;
        vec1    = (code_i == CODE_SA0) && (&d_i) && clk_i;
        ones    = $countones(lines_i);
        apply_o = vec0 || vec1;
        err_o   = (vec0 && ones != 0) || (vec1 && ones != NLINES);
    end
endmodule

// File: rtl/tcff_ms.sv
module tcff_ms
    import tcff_pkg::*;
#(
    parameter int WIDTH = 4,
    localparam int GW = GARB_PER_BIT * WIDTH,
    localparam int NLINES = LINES_PER_BIT * WIDTH
) (
    input  logic             clk_i,
    input  logic [WIDTH-1:0] d_i,
    input  logic             ldr_c1_i,
    input  logic             ldr_c2_i,
    input  logic             flw_c1_i,
    input  logic             flw_c2_i,
    output logic [WIDTH-1:0] q_o,
    output logic [WIDTH-1:0] ldr_t1_o,
    output logic [WIDTH-1:0] flw_t1_o,
    output logic [GW-1:0]    garb_o,
    output logic             tv_apply_o,
    output logic             tv_err_o
);
    logic [3:0]        code;
    logic [NLINES-1:0] lines;

    always_comb code = {ldr_c1_i, ldr_c2_i, flw_c1_i, flw_c2_i};

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        tcff_slice u_slice (
            .clk_i   (clk_i),
            .d_i     (d_i[i]),
            .ldr_c1_i(ldr_c1_i),
            .ldr_c2_i(ldr_c2_i),
            .flw_c1_i(flw_c1_i),
            .flw_c2_i(flw_c2_i),
            .q_o     (q_o[i]),
            .ldr_t1_o(ldr_t1_o[i]),
            .flw_t1_o(flw_t1_o[i]),
            .garb_o  (garb_o[i*GARB_PER_BIT +: GARB_PER_BIT])
        );
    end

    always_comb lines = {garb_o, flw_t1_o, ldr_t1_o, q_o};

    tcff_vec_mon #(.WIDTH(WIDTH)) u_mon (
        .clk_i  (clk_i),
        .d_i    (d_i),
        .code_i (code),
        .lines_i(lines),
        .apply_o(tv_apply_o),
        .err_o  (tv_err_o)
    );
endmodule

// File: rtl/tcff_ms_chk.sv
module tcff_ms_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk_i,
    input logic [WIDTH-1:0] d_i,
    input logic             ldr_c1_i,
    input logic             ldr_c2_i,
    input logic             flw_c1_i,
    input logic             flw_c2_i,
    input logic [WIDTH-1:0] q_o,
    input logic [WIDTH-1:0] ldr_t1_o,
    input logic [WIDTH-1:0] flw_t1_o,
    input logic             tv_err_o
);
    logic [3:0]       code;
    logic             norm;
    logic             armed = 1'b0;
    logic             norm_fall = 1'b0;
    logic [WIDTH-1:0] d_fall = '0;

    always_comb begin
        code = {ldr_c1_i, ldr_c2_i, flw_c1_i, flw_c2_i};
        norm = (code == 4'b0101);
    end

    always_ff @(negedge clk_i) begin
        armed     <= 1'b1;
        norm_fall <= norm;
        d_fall    <= d_i;
    end

    // R1: value taken at the falling edge is on q when the next rising edge comes
    a_r1_q_from_fall: assert property (@(posedge clk_i) disable iff (!armed)
        (norm && norm_fall) |-> (q_o == d_fall));

    // R2: leader holds the falling-edge value during the low phase
    a_r2_leader_holds: assert property (@(posedge clk_i) disable iff (!armed)
        (norm && norm_fall) |-> (ldr_t1_o == d_fall));

    // R3: follower feedback copy tracks q
    a_r3_flw_copy: assert property (@(posedge clk_i) disable iff (!armed)
        norm |-> (flw_t1_o == q_o));

    // R4: stuck-at-1 code forces feedback copies low
    a_r4_sa1_low: assert property (@(posedge clk_i) disable iff (!armed)
        (code == 4'b0000) |-> (ldr_t1_o == '0 && flw_t1_o == '0));

    // R5: stuck-at-0 code forces feedback copies high
    a_r5_sa0_high: assert property (@(posedge clk_i) disable iff (!armed)
        (code == 4'b1111) |-> (&ldr_t1_o && &flw_t1_o));

    // R8: fault-free bank never raises the monitor error
    a_r8_no_err: assert property (@(negedge clk_i) disable iff (!armed)
        !tv_err_o);

    // R9: only the three defined control codes appear
    a_r9_legal_code: assert property (@(posedge clk_i) disable iff (!armed)
        (code == 4'b0000 || code == 4'b0101 || code == 4'b1111));
endmodule

bind tcff_ms tcff_ms_chk #(.WIDTH(WIDTH)) u_chk (
    .clk_i   (clk_i),
    .d_i     (d_i),
    .ldr_c1_i(ldr_c1_i),
    .ldr_c2_i(ldr_c2_i),
    .flw_c1_i(flw_c1_i),
    .flw_c2_i(flw_c2_i),
    .q_o     (q_o),
    .ldr_t1_o(ldr_t1_o),
    .flw_t1_o(flw_t1_o),
    .tv_err_o(tv_err_o)
);

// File: tb/test_tcff_ms.sv
`timescale 1ns/1ps
module test_tcff_ms;
    localparam int W  = 4;
    localparam int GW = 5 * W;

    logic          clk = 1'b0;
    logic [W-1:0]  d = '0;
    logic          lc1 = 1'b0, lc2 = 1'b1, fc1 = 1'b0, fc2 = 1'b1;
    logic [W-1:0]  q, lt1, ft1;
    logic [GW-1:0] garb;
    logic          tv_apply, tv_err;

    int n_chk = 0;
    int n_fail = 0;

    tcff_ms #(.WIDTH(W)) i_tcff_ms (
        .clk_i     (clk),
        .d_i       (d),
        .ldr_c1_i  (lc1),
        .ldr_c2_i  (lc2),
        .flw_c1_i  (fc1),
        .flw_c2_i  (fc2),
        .q_o       (q),
        .ldr_t1_o  (lt1),
        .flw_t1_o  (ft1),
        .garb_o    (garb),
        .tv_apply_o(tv_apply),
        .tv_err_o  (tv_err)
    );

    always #4 clk = ~clk;   // 125 MHz

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_code(input logic [3:0] c);
        {lc1, lc2, fc1, fc2} = c;
    endtask

    function automatic logic [W-1:0] pattern(input int k);
        logic [W-1:0] p;
        p = '0;
        for (int b = 0; b < W; b++) begin
            case (k)
                0: p[b] = 1'b0;
                1: p[b] = 1'b1;
                2: p[b] = b[0];
                default: p[b] = ~b[0];
            endcase
        end
        return p;
    endfunction

    initial begin
        #1_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [W-1:0] ref_q;
        logic [W-1:0] fall_q[$];
        logic         have_ref;
        have_ref = 1'b0;
        ref_q    = '0;
        set_code(4'b0101);

        // Normal operation: fixed patterns, then random words
        for (int it = 0; it < 40; it++) begin
            @(posedge clk);
            #1 d = (it < 4) ? pattern(it) : W'($urandom);
            #1;
            check("R2 leader transparent in high phase", 64'(lt1), 64'(d));
            if (have_ref) begin
                check("R1 q holds through rising edge", 64'(q), 64'(ref_q));
                check("R3 follower copy equals q", 64'(ft1), 64'(q));
            end
            @(negedge clk);
            fall_q.push_back(d);
            ref_q    = fall_q.pop_front();
            have_ref = 1'b1;
            #1 d = ~d;   // change in low phase: must not reach q or leader
            #1;
            check("R1 q equals d at falling edge", 64'(q), 64'(ref_q));
            check("R2 leader holds in low phase", 64'(lt1), 64'(ref_q));
            check("R3 follower copy equals q", 64'(ft1), 64'(ref_q));
            check("R11 per-bit independence", 64'(q ^ ref_q), 64'(0));
        end

        // Stuck-at-1 test code
        @(posedge clk);
        #1 set_code(4'b0000);
        d = pattern(2);
        #1;
        check("R4 leader copy forced low", 64'(lt1), 64'(0));
        check("R4 follower copy forced low", 64'(ft1), 64'(0));
        check("R8 no apply with wrong phase", 64'(tv_apply), 64'(0));
        @(negedge clk);
        #1 d = '0;
        #1;
        check("R6 q low", 64'(q), 64'(0));
        check("R6 feedback copies low", 64'({lt1, ft1}), 64'(0));
        check("R6 garbage low", 64'(garb), 64'(0));
        check("R8 apply on all-0s vector", 64'(tv_apply), 64'(1));
        check("R8 no error on all-0s vector", 64'(tv_err), 64'(0));

        // Stuck-at-0 test code
        @(posedge clk);
        #1 set_code(4'b1111);
        d = '1;
        #1;
        check("R7 q high", 64'(q), 64'({W{1'b1}}));
        check("R7 feedback copies high", 64'({lt1, ft1}), 64'({2*W{1'b1}}));
        check("R7 garbage high", 64'(garb), 64'({GW{1'b1}}));
        check("R8 apply on all-1s vector", 64'(tv_apply), 64'(1));
        check("R8 no error on all-1s vector", 64'(tv_err), 64'(0));
        @(negedge clk);
        #1 d = pattern(3);
        #1;
        check("R5 leader copy forced high", 64'(lt1), 64'({W{1'b1}}));
        check("R5 follower copy forced high", 64'(ft1), 64'({W{1'b1}}));
        check("R8 no apply with wrong phase", 64'(tv_apply), 64'(0));

        // Back to normal operation
        for (int it = 0; it < 6; it++) begin
            @(posedge clk);
            #1 set_code(4'b0101);
            d = (it == 0) ? pattern(2) : W'($urandom);
            @(negedge clk);
            ref_q = d;
            #1 d = ~d;
            #1;
            check("R10 q recovers after test code", 64'(q), 64'(ref_q));
            check("R10 follower copy recovers", 64'(ft1), 64'(ref_q));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule